// File: doc/BRIEF.md
# Page-Buffered Write Controller for a Serial Memory

This block sits between a two-wire slave protocol engine and a byte-wide storage array. It owns the word-address counter and a one-page holding latch. The protocol engine reports four kinds of event: an address has been received, a data byte has been received, the host wants the next read byte, and the bus transaction has stopped. Data bytes do not go to the array straight away. They collect in the latch, and each byte is marked with the column it belongs to. When the transaction stops and at least one data byte has been collected, the block runs a programming cycle. It copies every marked column of the addressed page into the array over a synchronous memory port and holds a busy flag for a fixed number of clock cycles.

The array has 2^ROW_AW pages of 2^COL_AW bytes each. The defaults are 256 pages of 64 bytes, which gives a 14-bit address. The address counter advances in two different ways. During writes only the column part moves, so the address wraps inside the current page. During reads the whole address moves, so it wraps from the top of the array to address zero. The counter keeps its value between transactions. A write-protect input blocks every change to the array.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset, `cur_addr` is 0, `busy` is low, and no memory write occurs.
- R2: An accepted `ev_load` sets `cur_addr` to `ld_addr` on the next cycle.
- R3: An accepted `ev_data` stores `wr_data` for column `cur_addr[COL_AW-1:0]`. It then adds one to that column field modulo 2^COL_AW and leaves the page field `cur_addr[AW-1:COL_AW]` unchanged, so column 63 wraps to column 0 of the same page.
- R4: When more bytes than a page holds arrive in one transaction, the byte received last for a column is the one written to that column.
- R5: An accepted `ev_read` reads the array at `cur_addr`. In the next cycle `rd_valid` is high and `rd_data` holds that byte, and `cur_addr` has gone up by one modulo 2^AW, so the top address wraps to 0.
- R6: An `ev_stop` accepted while `wp` is low, after at least one data byte since the last `ev_load`, raises `busy` in the next cycle. `busy` then stays high for exactly PROG_CYCLES cycles.
- R7: The programming cycle writes only the columns that received a byte, and only within the page held by `cur_addr`. Every other array location keeps its value.
- R8: `mem_we` is never high while `wp` is high. An `ev_stop` with `wp` high starts no programming cycle and discards the collected bytes.
- R9: An `ev_stop` with no data byte since the last `ev_load` starts no programming cycle and leaves `cur_addr` unchanged.
- R10: While `busy` is high, every event is ignored. `cur_addr`, the collected bytes and `rd_valid` are not affected.
- R11: `cur_addr` keeps its value across transactions. After a committed write it points one column past the last byte written, and a later read starts from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_load | input | 1 | Address received; load counter and open a new write collection |
| ld_addr | input | AW | Address to load |
| ev_data | input | 1 | Data byte received in a write transaction |
| wr_data | input | DW | Received data byte |
| ev_read | input | 1 | Fetch the byte at the counter and advance |
| ev_stop | input | 1 | Bus stop condition seen |
| wp | input | 1 | Write protect, high blocks all array changes |
| busy | output | 1 | Programming cycle in progress |
| cur_addr | output | AW | Word-address counter |
| rd_data | output | DW | Byte returned by the last fetch |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| mem_en | output | 1 | Memory port access strobe |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | AW | Memory port address |
| mem_wdata | output | DW | Memory port write data |
| mem_rdata | input | DW | Memory port read data, valid one cycle after a read strobe |

## Verification
The assertions assume that the protocol engine raises at most one event in any cycle. They also assume that the memory returns read data exactly one cycle after a read strobe, and that `wp` only changes while no programming cycle is running. The bench drives each event as a single-cycle pulse on its own. It changes `wp` only between transactions, while `busy` is low. Its memory model answers reads with a one-cycle registered output, and the design is built with a small configuration of eight pages so that the bench can compare the whole array against its own model.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_PROG = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic load;
    logic data;
    logic read;
    logic stop;
  } pgw_evt_t;

endpackage

// File: rtl/pgw_addr_ctr.sv
module pgw_addr_ctr #(
  parameter int ROW_AW = 8,
  parameter int COL_AW = 6,
  localparam int AW = ROW_AW + COL_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic          col_step,
  input  logic          lin_step,
  output logic [AW-1:0] addr
);

  logic [AW-1:0]     addr_q;
  logic [AW-1:0]     addr_d;
  logic [COL_AW-1:0] col_inc;
  logic              addr_en;

  // column increment stays inside the page; linear increment spans the array
  assign col_inc = addr_q[COL_AW-1:0] + COL_AW'(1);
  assign addr_en = ld | col_step | lin_step;

  always_comb begin
    addr_d = addr_q;
    if (ld) begin
      addr_d = ld_addr;
    end else if (col_step) begin
      addr_d = {addr_q[AW-1:COL_AW], col_inc};
    end else if (lin_step) begin
      addr_d = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/pgw_page_latch.sv
module pgw_page_latch #(
  parameter int COL_AW = 6,
  parameter int DW     = 8,
  localparam int NCOL  = 1 << COL_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [COL_AW-1:0] wr_col,
  input  logic [DW-1:0]     wr_data,
  input  logic [COL_AW-1:0] sel_col,
  output logic [DW-1:0]     sel_data,
  output logic              sel_valid,
  output logic              any_valid
);

  logic [NCOL-1:0] valid_q;
  logic [NCOL-1:0] wr_hit;
  logic [DW-1:0]   data_q [NCOL];

  for (genvar c = 0; c < NCOL; c++) begin : g_col_dec
    assign wr_hit[c] = wr_en && (wr_col == COL_AW'(c));
  end

  // marks: cleared when a collection opens or is consumed, set per column on write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (clr) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q <= valid_q | wr_hit;
    end
  end

  // data storage needs no reset: a column is only read when its mark is set
  always_ff @(posedge clk) begin
    for (int c = 0; c < NCOL; c++) begin
      if (wr_hit[c]) begin
        data_q[c] <= wr_data;
      end
    end
  end

  assign sel_data  = data_q[sel_col];
  assign sel_valid = valid_q[sel_col];
  assign any_valid = |valid_q;

endmodule

// File: rtl/pgw_commit_seq.sv
module pgw_commit_seq
  import pgw_pkg::*;
#(
  parameter int COL_AW      = 6,
  parameter int PROG_CYCLES = 250,
  localparam int NCOL       = 1 << COL_AW,
  localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              scan_on,
  output logic [COL_AW-1:0] scan_col,
  output logic              done
);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic          last_cyc;

  assign last_cyc = (cyc_q == CW'(PROG_CYCLES - 1));

  always_comb begin
    state_d = state_q;
    cyc_d   = cyc_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_PROG;
          cyc_d   = '0;
        end
      end
      SEQ_PROG: begin
        if (last_cyc) begin
          state_d = SEQ_IDLE;
          cyc_d   = '0;
        end else begin
          cyc_d = cyc_q + CW'(1);
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cyc_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cyc_q   <= '0;
    end else begin
      state_q <= state_d;
      cyc_q   <= cyc_d;
    end
  end

  assign busy     = (state_q == SEQ_PROG);
  assign scan_on  = busy && (cyc_q < CW'(NCOL));
  assign scan_col = cyc_q[COL_AW-1:0];
  assign done     = busy && last_cyc;

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int ROW_AW      = 8,
  parameter int COL_AW      = 6,
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 250,
  localparam int AW         = ROW_AW + COL_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_load,
  input  logic [AW-1:0] ld_addr,
  input  logic          ev_data,
  input  logic [DW-1:0] wr_data,
  input  logic          ev_read,
  input  logic          ev_stop,
  input  logic          wp,
  output logic          busy,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  pgw_evt_t          acc;
  logic              start, done, latch_clr;
  logic              scan_on, sel_valid, any_valid, prog_wr;
  logic [COL_AW-1:0] scan_col;
  logic [DW-1:0]     sel_data;
  logic              rd_valid_q;

  // events are only taken while no programming cycle runs
  assign acc.load = ev_load & ~busy;
  assign acc.data = ev_data & ~busy;
  assign acc.read = ev_read & ~busy;
  assign acc.stop = ev_stop & ~busy;

  assign start     = acc.stop & any_valid & ~wp;
  assign latch_clr = acc.load | done | (acc.stop & ~start);

  pgw_addr_ctr #(
    .ROW_AW (ROW_AW),
    .COL_AW (COL_AW)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ld       (acc.load),
    .ld_addr  (ld_addr),
    .col_step (acc.data),
    .lin_step (acc.read),
    .addr     (cur_addr)
  );

  pgw_page_latch #(
    .COL_AW (COL_AW),
    .DW     (DW)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (latch_clr),
    .wr_en     (acc.data),
    .wr_col    (cur_addr[COL_AW-1:0]),
    .wr_data   (wr_data),
    .sel_col   (scan_col),
    .sel_data  (sel_data),
    .sel_valid (sel_valid),
    .any_valid (any_valid)
  );

  pgw_commit_seq #(
    .COL_AW      (COL_AW),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .busy     (busy),
    .scan_on  (scan_on),
    .scan_col (scan_col),
    .done     (done)
  );

  // commit writes gated by the protect pin a second time
  assign prog_wr   = scan_on & sel_valid & ~wp;

  assign mem_en    = prog_wr | acc.read;
  assign mem_we    = prog_wr;
  assign mem_addr  = busy ? {cur_addr[AW-1:COL_AW], scan_col} : cur_addr;
  assign mem_wdata = sel_data;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= acc.read;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = mem_rdata;

endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk #(
  parameter int AW          = 14,
  parameter int COL_AW      = 6,
  parameter int PROG_CYCLES = 250,
  localparam int CW         = $clog2(PROG_CYCLES + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_load,
  input logic          ev_data,
  input logic          ev_read,
  input logic          ev_stop,
  input logic          wp,
  input logic          busy,
  input logic [AW-1:0] cur_addr,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          rd_valid
);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (busy) begin
      run_q <= run_q + CW'(1);
    end else begin
      run_q <= '0;
    end
  end

  // R1
  a_r1_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R3
  a_r3_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data && !busy && !ev_load) |=>
      (cur_addr[COL_AW-1:0] == $past(cur_addr[COL_AW-1:0]) + 1'b1) &&
      (cur_addr[AW-1:COL_AW] == $past(cur_addr[AW-1:COL_AW])));

  // R5
  a_r5_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_read && !busy && !ev_load && !ev_data) |=>
      rd_valid && (cur_addr == $past(cur_addr) + 1'b1));

  // R6
  a_r6_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop && !wp));

  // R6
  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == CW'(PROG_CYCLES)));

  // R7
  a_r7_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[AW-1:COL_AW] == cur_addr[AW-1:COL_AW]) && mem_en);

  // R8
  a_r8_protect: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp);

  // R10
  a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr));

  // R10
  a_r10_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid);

endmodule

bind pgw_ctrl pgw_ctrl_chk #(
  .AW          (AW),
  .COL_AW      (COL_AW),
  .PROG_CYCLES (PROG_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .ev_load  (ev_load),
  .ev_data  (ev_data),
  .ev_read  (ev_read),
  .ev_stop  (ev_stop),
  .wp       (wp),
  .busy     (busy),
  .cur_addr (cur_addr),
  .mem_en   (mem_en),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .rd_valid (rd_valid)
);

// File: tb/test_pgw_ctrl.sv
module test_pgw_ctrl;

  localparam int ROW_AW = 3;
  localparam int COL_AW = 6;
  localparam int DW     = 8;
  localparam int PROG   = 80;
  localparam int AW     = ROW_AW + COL_AW;
  localparam int NADDR  = 1 << AW;
  localparam int NCOL   = 1 << COL_AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_load = 1'b0, ev_data = 1'b0, ev_read = 1'b0, ev_stop = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wp = 1'b0;
  logic          busy, rd_valid, mem_en, mem_we;
  logic [AW-1:0] cur_addr, mem_addr;
  logic [DW-1:0] rd_data, mem_wdata;
  logic [DW-1:0] rdq = '0;

  always #10 clk = ~clk;

  pgw_ctrl #(
    .ROW_AW (ROW_AW), .COL_AW (COL_AW), .DW (DW), .PROG_CYCLES (PROG)
  ) i_pgw_ctrl (
    .clk (clk), .rst_n (rst_n),
    .ev_load (ev_load), .ld_addr (ld_addr),
    .ev_data (ev_data), .wr_data (wr_data),
    .ev_read (ev_read), .ev_stop (ev_stop), .wp (wp),
    .busy (busy), .cur_addr (cur_addr),
    .rd_data (rd_data), .rd_valid (rd_valid),
    .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_rdata (rdq)
  );

  // bench memory and its reference copy
  logic [DW-1:0] mem     [NADDR];
  logic [DW-1:0] ref_mem [NADDR];
  int wr_count = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_count      <= wr_count + 1;
      end else begin
        rdq <= mem[mem_addr];
      end
    end
  end

  // bench model of counter and collected bytes
  int          exp_addr = 0;
  logic        pend_v [NCOL];
  logic [7:0]  pend_d [NCOL];
  int          pend_row = 0;
  int          total = 0, fails = 0;

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit l, input bit d, input bit r, input bit s,
                       input int a, input int v);
    @(negedge clk);
    ev_load = l; ev_data = d; ev_read = r; ev_stop = s;
    ld_addr = AW'(a); wr_data = DW'(v);
    @(negedge clk);
    ev_load = 0; ev_data = 0; ev_read = 0; ev_stop = 0;
    #1;
  endtask

  task automatic do_load(input int a);
    pulse(1, 0, 0, 0, a, 0);
    exp_addr = a % NADDR;
    pend_row = exp_addr / NCOL;
    for (int c = 0; c < NCOL; c++) pend_v[c] = 1'b0;
  endtask

  task automatic do_byte(input int v);
    int col;
    pulse(0, 1, 0, 0, 0, v);
    col = exp_addr % NCOL;
    pend_v[col] = 1'b1;
    pend_d[col] = 8'(v);
    exp_addr = pend_row * NCOL + ((col + 1) % NCOL);
  endtask

  task automatic do_read(input string tag);
    int exp;
    exp = ref_mem[exp_addr];
    pulse(0, 0, 1, 0, 0, 0);
    chk(rd_valid === 1'b1 && rd_data === 8'(exp), tag, int'(rd_data), exp);
    exp_addr = (exp_addr + 1) % NADDR;
  endtask

  // returns number of busy cycles observed
  task automatic do_stop(output int n);
    bit any;
    any = 0;
    for (int c = 0; c < NCOL; c++) any |= pend_v[c];
    pulse(0, 0, 0, 1, 0, 0);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    if (any && !wp) begin
      for (int c = 0; c < NCOL; c++)
        if (pend_v[c]) ref_mem[pend_row * NCOL + c] = pend_d[c];
    end
    for (int c = 0; c < NCOL; c++) pend_v[c] = 1'b0;
  endtask

  task automatic cmp_mem(input string tag);
    int bad;
    bad = -1;
    for (int a = NADDR - 1; a >= 0; a--) if (mem[a] !== ref_mem[a]) bad = a;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, int'(mem[bad]), int'(ref_mem[bad]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int n, w0;
    for (int a = 0; a < NADDR; a++) begin
      mem[a]     = 8'(a * 7 + 3);
      ref_mem[a] = 8'(a * 7 + 3);
    end
    for (int c = 0; c < NCOL; c++) begin
      pend_v[c] = 1'b0;
      pend_d[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R1 reset state
    chk(cur_addr === '0, "R1 addr", int'(cur_addr), 0);
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(wr_count == 0, "R1 writes", wr_count, 0);

    // R2 load
    do_load(9'h0A5);
    chk(cur_addr === AW'(9'h0A5), "R2 load", int'(cur_addr), 9'h0A5);

    // R3 column wrap inside page 2
    do_load(2 * NCOL + 62);
    do_byte(8'hA1);
    chk(int'(cur_addr) == exp_addr, "R3 step", int'(cur_addr), exp_addr);
    do_byte(8'hA2);
    chk(int'(cur_addr) == 2 * NCOL, "R3 wrap", int'(cur_addr), 2 * NCOL);
    do_byte(8'hA3);
    w0 = wr_count;
    do_stop(n);
    chk(n == PROG, "R6 busy length", n, PROG);
    chk(wr_count - w0 == 3, "R7 write count", wr_count - w0, 3);
    cmp_mem("R7 partial page");

    // R11 address kept, read continues from it
    chk(int'(cur_addr) == 2 * NCOL + 1, "R11 addr after write", int'(cur_addr), 2 * NCOL + 1);
    do_read("R11 read continues");

    // R4 overflow past one page
    do_load(5 * NCOL + 10);
    for (int i = 0; i < 70; i++) do_byte(8'h40 + i);
    w0 = wr_count;
    do_stop(n);
    chk(wr_count - w0 == NCOL, "R4 write count", wr_count - w0, NCOL);
    cmp_mem("R4 overwrite");

    // R8 protected stop
    wp = 1'b1;
    do_load(3 * NCOL + 5);
    do_byte(8'h55);
    do_byte(8'h66);
    w0 = wr_count;
    do_stop(n);
    chk(n == 0, "R8 no busy", n, 0);
    chk(wr_count == w0, "R8 no write", wr_count - w0, 0);
    wp = 1'b0;
    cmp_mem("R8 array unchanged");

    // R9 stop after address only
    do_load(4 * NCOL + 33);
    do_stop(n);
    chk(n == 0, "R9 no busy", n, 0);
    chk(int'(cur_addr) == 4 * NCOL + 33, "R9 addr kept", int'(cur_addr), 4 * NCOL + 33);

    // R10 events ignored while busy
    do_load(1 * NCOL);
    do_byte(8'h11);
    pulse(0, 0, 0, 1, 0, 0);
    chk(busy === 1'b1, "R10 busy up", int'(busy), 1);
    pulse(1, 0, 0, 0, 9'h100, 0);
    pulse(0, 1, 0, 0, 0, 8'hEE);
    pulse(0, 0, 1, 0, 0, 0);
    chk(rd_valid === 1'b0, "R10 read ignored", int'(rd_valid), 0);
    chk(int'(cur_addr) == NCOL + 1, "R10 addr held", int'(cur_addr), NCOL + 1);
    ref_mem[NCOL] = 8'h11;
    for (int c = 0; c < NCOL; c++) pend_v[c] = 1'b0;
    while (busy === 1'b1) begin @(negedge clk); #1; end
    cmp_mem("R10 latch untouched");

    // R7 sweep: one byte per page at varying columns
    for (int p = 0; p < (1 << ROW_AW); p++) begin
      do_load(p * NCOL + ((p * 9) % NCOL));
      do_byte(8'hC0 + p);
      do_stop(n);
    end
    cmp_mem("R7 page sweep");

    // R5 full read sweep with top wrap
    do_load(0);
    for (int a = 0; a < NADDR; a++) do_read("R5 sweep");
    chk(cur_addr === '0, "R5 wrap to zero", int'(cur_addr), 0);
    do_load(NADDR - 1);
    do_read("R5 top byte");
    do_read("R5 after wrap");

    summary();
    $finish;
  end

endmodule